// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Control

This block holds the configuration that steers three 128 KB windows of the upper memory area. Each window goes either to internal shadow DRAM or to the external bus and ROM. Software reaches the configuration through two byte-wide I/O ports on a single-cycle strobe interface. Read data comes back in the same cycle as the read strobe.

For every memory access the block takes the address and the direction. It returns a combinational route-internal select and a write-suppress flag. Any write that alters a routing or write-protect control bit raises a one-cycle change pulse. The cache logic uses that pulse to flush stale translations.

A one-way lock hides both ports after it is set. Reads then return 0xFF and writes are ignored, while the routing already programmed stays in force until the next reset.

Top module: `shadow_route_ctrl`

## Requirements
- R1: Only I/O addresses 0x22 (port A) and 0x23 (port B) are decoded, with the full address compared. A read of any other address, or with the read strobe low, returns 0xFF. A write to any other address changes nothing.
- R2: After reset, port A reads 0xD8, port B reads 0x00, the lock is clear, and every window routes externally.
- R3: A write to port A stores the written byte ORed with 0xD8, so bits 7, 6, 4 and 3 of port A always read 1.
- R4: Port A bit 0 set routes the window 0xE0000–0xFFFFF internally for reads and writes. Clear routes it externally.
- R5: Port B bit 1 set routes the window 0xC0000–0xDFFFF internally for reads and writes. Clear routes it externally.
- R6: The window 0xA0000–0xBFFFF takes its routing from port B bit 1 as well.
- R7: With port B bit 3 set, a write (mem_we_i=1) into 0xA0000–0xBFFFF raises wr_block_o, whatever the routing. Reads are never suppressed.
- R8: Addresses below 0xA0000 are never routed internally and never write-suppressed.
- R9: A port write that changes port A bit 0, port B bit 1 or port B bit 3 raises route_chg_o for exactly the one cycle after the write edge. A write that leaves all three bits unchanged raises no pulse.
- R10: A write to port B with bit 7 set stores the byte and then locks the block. From then until reset, both ports read 0xFF, writes to them are ignored and raise no pulse, and the routing holds.
- R11: Port reads and the routing outputs are combinational and respond in the same cycle as their inputs. Register updates show up on them right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write data |
| io_we_i | input | 1 | I/O write strobe |
| io_re_i | input | 1 | I/O read strobe |
| io_rdata_o | output | 8 | I/O read data, same cycle |
| mem_addr_i | input | 20 | Memory access address |
| mem_we_i | input | 1 | Memory access is a write |
| route_int_o | output | 1 | Route access to internal shadow DRAM |
| wr_block_o | output | 1 | Suppress this memory write |
| route_chg_o | output | 1 | One-cycle routing change pulse |

## Verification
Port read data and both routing outputs are due in the same cycle as their inputs. The bench applies them after a falling edge and samples one time step later, with no clock edge in between. A port write takes effect at the rising edge that follows it. The change pulse is registered on that same edge, so the bench checks route_chg_o at the next falling edge, expecting it high or low, and checks it low again one full cycle later. Routing is swept over 32 addresses in both directions for every port B value without bit 7, once with port A bit 0 clear and once with it set.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef struct packed {
    logic hi_en;   // top window internal
    logic mid_en;  // lower two windows internal
    logic vid_wp;  // lowest window write-protect
  } route_cfg_t;

  localparam logic [7:0] CFG_A_FORCE = 8'hD8;
  localparam logic [7:0] CFG_B_RST   = 8'h00;
  localparam int BIT_HI_EN  = 0;
  localparam int BIT_MID_EN = 1;
  localparam int BIT_VID_WP = 3;
  localparam int BIT_LOCK   = 7;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
#(
  parameter int              IO_AW  = 16,
  parameter logic [IO_AW-1:0] PORT_A = 16'h0022,
  parameter logic [IO_AW-1:0] PORT_B = 16'h0023
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [7:0]       io_wdata_i,
  input  logic             io_we_i,
  input  logic             io_re_i,
  output logic [7:0]       io_rdata_o,
  output route_cfg_t       cfg_o,
  output route_cfg_t       cfg_nxt_o,
  output logic             lock_o
);
  logic [7:0] reg_a_q, reg_b_q;
  logic       lock_q;
  logic       sel_a, sel_b;
  logic [7:0] reg_a_d, reg_b_d;

  assign sel_a = (io_addr_i == PORT_A) && !lock_q;
  assign sel_b = (io_addr_i == PORT_B) && !lock_q;

  always_comb begin
    reg_a_d = reg_a_q;
    reg_b_d = reg_b_q;
    if (io_we_i && sel_a) reg_a_d = io_wdata_i | CFG_A_FORCE;
    if (io_we_i && sel_b) reg_b_d = io_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_q <= CFG_A_FORCE;
      reg_b_q <= CFG_B_RST;
      lock_q  <= 1'b0;
    end else begin
      reg_a_q <= reg_a_d;
      reg_b_q <= reg_b_d;
      if (io_we_i && sel_b && io_wdata_i[BIT_LOCK]) lock_q <= 1'b1;
    end
  end

  always_comb begin
    io_rdata_o = 8'hFF;
    if (io_re_i && sel_a) io_rdata_o = reg_a_q;
    else if (io_re_i && sel_b) io_rdata_o = reg_b_q;
  end

  assign cfg_o     = '{hi_en: reg_a_q[BIT_HI_EN], mid_en: reg_b_q[BIT_MID_EN],
                       vid_wp: reg_b_q[BIT_VID_WP]};
  assign cfg_nxt_o = '{hi_en: reg_a_d[BIT_HI_EN], mid_en: reg_b_d[BIT_MID_EN],
                       vid_wp: reg_b_d[BIT_VID_WP]};
  assign lock_o    = lock_q;
endmodule

// File: rtl/shadow_chg_pulse.sv
module shadow_chg_pulse
  import shadow_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  route_cfg_t cfg_i,
  input  route_cfg_t cfg_nxt_i,
  output logic       chg_o
);
  logic chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= 1'b0;
    else         chg_q <= (cfg_nxt_i != cfg_i);
  end

  assign chg_o = chg_q;
endmodule

// File: rtl/shadow_win_decode.sv
module shadow_win_decode #(
  parameter int MEM_AW   = 20,
  parameter int WIN_AW   = 17,
  parameter int NUM_WIN  = 3,
  parameter int BASE_TAG = 5
) (
  input  logic [MEM_AW-1:0] mem_addr_i,
  input  logic              mem_we_i,
  input  logic [NUM_WIN-1:0] win_int_i,
  input  logic [NUM_WIN-1:0] win_wp_i,
  output logic              route_int_o,
  output logic              wr_block_o
);
  localparam int TAG_W = MEM_AW - WIN_AW;

  logic [TAG_W-1:0]   tag;
  logic [NUM_WIN-1:0] hit;

  assign tag = mem_addr_i[MEM_AW-1:WIN_AW];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit[w] = (tag == TAG_W'(BASE_TAG + w));
  end

  assign route_int_o = |(hit & win_int_i);
  assign wr_block_o  = mem_we_i && |(hit & win_wp_i);
endmodule

// File: rtl/shadow_route_ctrl.sv
module shadow_route_ctrl
  import shadow_pkg::*;
#(
  parameter int               IO_AW  = 16,
  parameter int               MEM_AW = 20,
  parameter logic [IO_AW-1:0] PORT_A = 16'h0022,
  parameter logic [IO_AW-1:0] PORT_B = 16'h0023
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [7:0]        io_wdata_i,
  input  logic              io_we_i,
  input  logic              io_re_i,
  output logic [7:0]        io_rdata_o,
  input  logic [MEM_AW-1:0] mem_addr_i,
  input  logic              mem_we_i,
  output logic              route_int_o,
  output logic              wr_block_o,
  output logic              route_chg_o
);
  localparam int WIN_AW  = 17;  // 128 KB windows
  localparam int NUM_WIN = 3;
  localparam int BASE_TAG = (1 << (MEM_AW - WIN_AW)) - NUM_WIN;

  route_cfg_t         cfg, cfg_nxt;
  logic               lock_q;
  logic [NUM_WIN-1:0] win_int, win_wp;

  shadow_cfg_regs #(.IO_AW(IO_AW), .PORT_A(PORT_A), .PORT_B(PORT_B)) u_regs (
    .clk_i, .rst_ni, .io_addr_i, .io_wdata_i, .io_we_i, .io_re_i,
    .io_rdata_o, .cfg_o(cfg), .cfg_nxt_o(cfg_nxt), .lock_o(lock_q)
  );

  shadow_chg_pulse u_chg (
    .clk_i, .rst_ni, .cfg_i(cfg), .cfg_nxt_i(cfg_nxt), .chg_o(route_chg_o)
  );

  // window 0 lowest (video), 1 middle, 2 top
  assign win_int = {cfg.hi_en, cfg.mid_en, cfg.mid_en};
  assign win_wp  = {1'b0, 1'b0, cfg.vid_wp};

  shadow_win_decode #(.MEM_AW(MEM_AW), .WIN_AW(WIN_AW), .NUM_WIN(NUM_WIN),
                      .BASE_TAG(BASE_TAG)) u_dec (
    .mem_addr_i, .mem_we_i, .win_int_i(win_int), .win_wp_i(win_wp),
    .route_int_o, .wr_block_o
  );
endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk #(
  parameter int               IO_AW  = 16,
  parameter int               MEM_AW = 20,
  parameter logic [IO_AW-1:0] PORT_A = 16'h0022,
  parameter logic [IO_AW-1:0] PORT_B = 16'h0023
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IO_AW-1:0]  io_addr_i,
  input logic              io_we_i,
  input logic              io_re_i,
  input logic [7:0]        io_rdata_o,
  input logic [MEM_AW-1:0] mem_addr_i,
  input logic              mem_we_i,
  input logic              route_int_o,
  input logic              wr_block_o,
  input logic              route_chg_o,
  input logic              lock_i
);
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_FIXED_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_re_i && io_addr_i == PORT_A |-> (io_rdata_o & 8'hD8) == 8'hD8); // R3

  AST_UNDECODED_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_re_i && io_addr_i != PORT_A && io_addr_i != PORT_B |-> io_rdata_o == 8'hFF); // R1

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> lock_i); // R10

  AST_LOCK_HIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && io_re_i |-> io_rdata_o == 8'hFF); // R10

  AST_LOW_EXTERNAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_addr_i[MEM_AW-1 -: 3] < 3'd5 |-> !route_int_o && !wr_block_o); // R8

  AST_READ_NO_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_i |-> !wr_block_o); // R7

  AST_CHG_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_chg_o |-> past_ok_q && $past(io_we_i)); // R9

  AST_ROUTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(io_we_i) && $stable(mem_addr_i) && $stable(mem_we_i)
    |-> $stable(route_int_o) && $stable(wr_block_o)); // R4
endmodule

bind shadow_route_ctrl shadow_route_chk #(
  .IO_AW(IO_AW), .MEM_AW(MEM_AW), .PORT_A(PORT_A), .PORT_B(PORT_B)
) u_chk (
  .clk_i, .rst_ni, .io_addr_i, .io_we_i, .io_re_i, .io_rdata_o,
  .mem_addr_i, .mem_we_i, .route_int_o, .wr_block_o, .route_chg_o,
  .lock_i(lock_q)
);

// File: tb/shadow_route_ctrl_tb_top.sv
module shadow_route_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [7:0]  io_wdata_i = '0;
  logic        io_we_i = 1'b0, io_re_i = 1'b0;
  logic [7:0]  io_rdata_o;
  logic [19:0] mem_addr_i = '0;
  logic        mem_we_i = 1'b0;
  logic        route_int_o, wr_block_o, route_chg_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_a, m_b;
  logic       m_lock;

  always #2 clk_i = ~clk_i;

  shadow_route_ctrl dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_route(input logic [19:0] a);
    case (a[19:17])
      3'b111:        return m_a[0];
      3'b110, 3'b101: return m_b[1];
      default:       return 1'b0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; io_we_i = 0; io_re_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    m_a = 8'hD8; m_b = 8'h00; m_lock = 0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    io_addr_i = a; io_re_i = 1'b1;
    #1 chk(req, io_rdata_o, exp);
    io_re_i = 1'b0;
  endtask

  // write, then check the pulse in the following cycle and its fall after it
  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] na, nb;
    logic       exp_chg;
    na = m_a; nb = m_b;
    if (!m_lock && a == 16'h0022) na = d | 8'hD8;
    if (!m_lock && a == 16'h0023) nb = d;
    exp_chg = (na[0] != m_a[0]) || (nb[1] != m_b[1]) || (nb[3] != m_b[3]);
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_we_i = 1'b1;
    @(negedge clk_i);
    io_we_i = 1'b0;
    if (!m_lock && a == 16'h0023 && d[7]) m_lock = 1'b1;
    m_a = na; m_b = nb;
    chk("R9 pulse", route_chg_o, exp_chg);
    @(negedge clk_i);
    chk("R9 pulse width", route_chg_o, 1'b0);
  endtask

  task automatic sweep_routes(input string req);
    for (int i = 0; i < 32; i++) begin
      for (int d = 0; d < 2; d++) begin
        logic [19:0] a;
        a = {i[4:0], 15'h0} | (i[0] ? 20'h07FFF : 20'h0);
        mem_addr_i = a; mem_we_i = d[0];
        #1;
        chk({req, " route"}, route_int_o, exp_route(a));
        chk({req, " R7 wr_block"}, wr_block_o,
            (a[19:17] == 3'b101) && d[0] && m_b[3]);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R2 reset state
    io_read(16'h0022, 8'hD8, "R2 port A");
    io_read(16'h0023, 8'h00, "R2 port B");
    sweep_routes("R2 R8");

    // R3 every byte into port A
    for (int v = 0; v < 256; v++) begin
      io_write(16'h0022, v[7:0]);
      io_read(16'h0022, v[7:0] | 8'hD8, "R3 readback");
    end

    // R1 undecoded addresses and strobe low
    io_write(16'h0024, 8'h00);
    io_write(16'h0122, 8'h00);
    io_write(16'h0021, 8'hFF);
    io_read(16'h0022, m_a, "R1 no alias");
    io_read(16'h0023, m_b, "R1 no alias B");
    io_read(16'h0024, 8'hFF, "R1 undecoded");
    io_read(16'h0123, 8'hFF, "R1 undecoded high");
    @(negedge clk_i); io_addr_i = 16'h0022; io_re_i = 1'b0;
    #1 chk("R1 strobe low", io_rdata_o, 8'hFF);

    // R4 R5 R6 R7 R8 R11: all port B values without lock, both top settings
    for (int h = 0; h < 2; h++) begin
      io_write(16'h0022, h[0] ? 8'h01 : 8'h00);
      for (int v = 0; v < 128; v++) begin
        io_write(16'h0023, v[7:0]);
        io_read(16'h0023, v[7:0], "R5 readback B");
        sweep_routes("R4 R5 R6 R8 R11");
      end
    end

    // R10 lock
    io_write(16'h0022, 8'h00);
    io_write(16'h0023, 8'h8A);
    io_read(16'h0022, 8'hFF, "R10 locked A");
    io_read(16'h0023, 8'hFF, "R10 locked B");
    io_write(16'h0022, 8'h01);
    io_write(16'h0023, 8'h00);
    sweep_routes("R10 routing held");
    io_read(16'h0023, 8'hFF, "R10 still locked");

    // R2 reset clears lock
    do_reset();
    io_read(16'h0022, 8'hD8, "R2 after lock A");
    io_read(16'h0023, 8'h00, "R2 after lock B");
    sweep_routes("R2 after lock");
    io_write(16'h0023, 8'h02);
    io_read(16'h0023, 8'h02, "R10 unlocked by reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule